// File: doc/BRIEF.md
# Interleaved Reed-Solomon Encoder

This block is a systematic Reed-Solomon encoder for 8-bit symbols. Each codeword carries 223 information symbols and 32 parity symbols (255 in all), which lets a decoder correct up to 16 symbol errors. The encoder holds the division remainders of up to five codewords at once. The information symbols therefore arrive already interleaved: column by column, one symbol from each codeword in turn. Each accepted symbol is copied straight to the output and also folded into the remainder of the codeword it belongs to. When the host drops the load mode, the encoder sends the 32 parity columns in the same interleaved order. The output stream is then ready to go to a burst-dispersing channel.

The field is GF(2^8), reduced by x^8+x^7+x^2+x+1, with primitive element 0x02. The generator polynomial has the 32 consecutive roots alpha^112 through alpha^143. This polynomial is self-reciprocal, so the 31 non-trivial coefficient products need only 16 distinct constant multipliers. Each multiplier works bit-serially: it takes one feedback bit per clock over eight clocks and uses only shifts and XORs. A host starts a group with a one-cycle start pulse that also sets the interleaving depth. It then streams the information symbols with a valid/ready handshake, and finally lowers the load mode to collect the parity.

Top module: `rs_ilv_encoder`

## Requirements
- R1: Every codeword in a group, read highest degree first, is made of its information symbols followed by 32 parity symbols. The parity symbols are the remainder of m(x)·x^32 divided by the generator, highest coefficient first. The whole codeword therefore evaluates to zero at alpha^112 through alpha^143.
- R2: An accepted information symbol appears unchanged on out_data, with out_valid high, in the cycle after the acceptance edge.
- R3: At depth d, the k-th accepted symbol of a group (counting from 0) belongs to codeword k mod d. After load_mode falls, exactly 32·d parity symbols are emitted on consecutive cycles, column by column with codeword 0 first. out_valid then stays low.
- R4: depth_sel is one-hot, and bit i selects depth i+1 (1 to 5). It is sampled only in a cycle where start is high.
- R5: A depth_sel value that is zero or has more than one bit set when start is sampled leaves the previous depth in force. The depth after reset is 1.
- R6: Changes of depth_sel between start pulses have no effect on the group in progress.
- R7: in_ready is high only when the encoder is waiting for a symbol and load_mode is 1. After an acceptance it is low for exactly 9 cycles: 8 multiply steps and 1 remainder update. It rises again on the 10th edge.
- R8: After reset, and again after the last parity symbol, in_ready and out_valid stay low until a start pulse.
- R9: A start pulse clears all remainder state. A group begun after an aborted group therefore encodes exactly as one begun from reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a group; clears the remainders and counters; samples depth_sel |
| depth_sel | input | 5 | One-hot interleaving depth; bit i means depth i+1 |
| load_mode | input | 1 | 1 = accept information symbols, 0 = emit parity |
| in_valid | input | 1 | Information symbol present |
| in_ready | output | 1 | Encoder can accept a symbol this cycle |
| in_data | input | 8 | Information symbol |
| out_valid | output | 1 | out_data holds a code symbol |
| out_data | output | 8 | Interleaved code symbol stream |

## Verification
The bench sweeps depths 1 to 5 with full-length groups and compares every output symbol against an independent long-division model. It also de-interleaves the captured stream and evaluates each codeword at all 32 roots. A wrong tap slot or a wrong word rotation would mix remainders between codewords, which shows up as nonzero root evaluations. A wrong constant multiplier or a wrong bit order would corrupt the parity. The bench programs an invalid depth (zero and two bits set) and changes depth_sel in the middle of a group. A design that latched either one would produce a stream of the wrong length or the wrong order. A group is aborted mid-way and then re-run, which exposes a start pulse that fails to clear the remainders. The bench times the ready gap and the parity length, which exposes an off-by-one in the multiply count or in the parity counter.

// File: rtl/rs_ilv_pkg.sv
package rs_ilv_pkg;

    localparam int SYM_W = 8;
    // low byte of the field polynomial x^8+x^7+x^2+x+1
    localparam logic [SYM_W-1:0] FIELD_LOW = 8'h87;

    typedef logic [SYM_W-1:0] sym_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_READY,
        PH_MUL,
        PH_UPD,
        PH_PAR
    } phase_e;

    typedef struct packed {
        logic accept;    // symbol taken this cycle
        logic mul_step;  // one bit-serial multiply step
        logic shift;     // remainder array advances one slot
        logic feed;      // products are added while shifting
        logic emit_par;  // head of array goes to the output
    } ctrl_t;

    // multiply by alpha (0x02)
    function automatic sym_t xtime(sym_t a);
        return {a[SYM_W-2:0], 1'b0} ^ (a[SYM_W-1] ? FIELD_LOW : '0);
    endfunction

    function automatic sym_t gf_mul(sym_t a, sym_t b);
        sym_t p;
        p = '0;
        for (int i = SYM_W - 1; i >= 0; i--) begin
            p = xtime(p);
            if (b[i]) p = p ^ a;
        end
        return p;
    endfunction

    // coefficient k of the generator with npar consecutive roots
    // centred so that the polynomial is self-reciprocal
    function automatic sym_t gen_coeff(int npar, int k);
        sym_t g [0:64];
        sym_t r;
        int   first;
        for (int i = 0; i <= 64; i++) g[i] = '0;
        g[0]  = 8'h01;
        first = (255 - npar + 1) / 2;
        r     = 8'h01;
        for (int e = 0; e < first; e++) r = xtime(r);
        for (int i = 0; i < npar; i++) begin
            for (int j = npar; j >= 1; j--) g[j] = g[j-1] ^ gf_mul(g[j], r);
            g[0] = gf_mul(g[0], r);
            r    = xtime(r);
        end
        return g[k];
    endfunction

endpackage

// File: rtl/rs_bitserial_bank.sv
module rs_bitserial_bank
    import rs_ilv_pkg::*;
#(
    parameter int NPAR = 32
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       load,
    input  logic                       step,
    input  sym_t                       fb_in,
    output logic [NPAR-1:0][SYM_W-1:0] prod_o
);
    localparam int NMUL = NPAR / 2;

    sym_t fb_hold;
    sym_t fb_sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            fb_hold <= '0;
            fb_sh   <= '0;
        end else if (load) begin
            fb_hold <= fb_in;
            fb_sh   <= fb_in;
        end else if (step) begin
            fb_sh   <= {fb_sh[SYM_W-2:0], 1'b0};
        end
    end

    // one accumulator per distinct generator coefficient g1..g(NPAR/2)
    for (genvar k = 1; k <= NMUL; k++) begin : mul_g
        localparam sym_t GK = gen_coeff(NPAR, k);
        sym_t acc_q;
        always_ff @(posedge clk) begin
            if (rst || load) acc_q <= '0;
            else if (step)   acc_q <= xtime(acc_q) ^ (fb_sh[SYM_W-1] ? GK : '0);
        end
    end

    assign prod_o[0] = fb_hold;  // g0 equals one
    for (genvar p = 1; p < NPAR; p++) begin : map_g
        localparam int K = (p <= NMUL) ? p : NPAR - p;
        assign prod_o[p] = mul_g[K].acc_q;
    end

endmodule

// File: rtl/rs_rem_array.sv
module rs_rem_array
    import rs_ilv_pkg::*;
#(
    parameter  int NPAR      = 32,
    parameter  int MAX_DEPTH = 5,
    localparam int DW        = $clog2(MAX_DEPTH + 1)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       clr,
    input  logic                       shift,
    input  logic                       feed,
    input  logic [DW-1:0]              depth,
    input  logic [NPAR-1:0][SYM_W-1:0] prod,
    output sym_t                       head
);
    logic [DW-1:0] tap_sel;
    sym_t          tap_w [NPAR];

    assign tap_sel = depth - DW'(1);

    for (genvar p = 0; p < NPAR; p++) begin : pos_g
        sym_t slot_q [MAX_DEPTH];
        sym_t carry;

        if (p == 0) begin : g_first
            assign carry = '0;
        end else begin : g_chain
            assign carry = tap_w[p-1];
        end

        assign tap_w[p] = slot_q[tap_sel];

        always_ff @(posedge clk) begin
            if (rst || clr) begin
                for (int j = 0; j < MAX_DEPTH; j++) slot_q[j] <= '0;
            end else if (shift) begin
                slot_q[0] <= carry ^ (feed ? sym_t'(prod[p]) : '0);
                for (int j = 1; j < MAX_DEPTH; j++) slot_q[j] <= slot_q[j-1];
            end
        end
    end

    assign head = tap_w[NPAR-1];

endmodule

// File: rtl/rs_seq.sv
module rs_seq
    import rs_ilv_pkg::*;
#(
    parameter  int NPAR      = 32,
    parameter  int MAX_DEPTH = 5,
    localparam int DW        = $clog2(MAX_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [MAX_DEPTH-1:0] depth_sel,
    input  logic                 load_mode,
    input  logic                 in_valid,
    output logic                 in_ready,
    output ctrl_t                ctrl,
    output logic [DW-1:0]        depth,
    output logic [DW-1:0]        wcnt
);
    localparam int BW = $clog2(SYM_W);
    localparam int PW = $clog2(NPAR * MAX_DEPTH + 1);

    phase_e        phase_q;
    logic [BW-1:0] bit_q;
    logic [PW-1:0] par_q;
    logic [DW-1:0] depth_q;
    logic [DW-1:0] wcnt_q;
    logic [DW-1:0] sel_depth;
    logic          sel_ok;
    logic          wrap;
    logic          par_done;

    always_comb begin
        sel_depth = '0;
        for (int i = 0; i < MAX_DEPTH; i++)
            if (depth_sel[i]) sel_depth = DW'(i + 1);
    end

    assign sel_ok   = $onehot(depth_sel);
    assign wrap     = (wcnt_q == depth_q - DW'(1));
    assign par_done = (par_q == PW'(NPAR * int'(depth_q) - 1));
    assign in_ready = (phase_q == PH_READY) && load_mode;

    always_comb begin
        ctrl.accept   = in_ready && in_valid && !start;
        ctrl.mul_step = (phase_q == PH_MUL);
        ctrl.feed     = (phase_q == PH_UPD);
        ctrl.emit_par = (phase_q == PH_PAR);
        ctrl.shift    = (phase_q == PH_UPD) || (phase_q == PH_PAR);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_IDLE;
            depth_q <= DW'(1);
            wcnt_q  <= '0;
            bit_q   <= '0;
            par_q   <= '0;
        end else if (start) begin
            phase_q <= PH_READY;
            wcnt_q  <= '0;
            bit_q   <= '0;
            par_q   <= '0;
            if (sel_ok) depth_q <= sel_depth;
        end else begin
            unique case (phase_q)
                PH_READY: begin
                    if (!load_mode) begin
                        phase_q <= PH_PAR;
                        par_q   <= '0;
                    end else if (in_valid) begin
                        phase_q <= PH_MUL;
                        bit_q   <= '0;
                    end
                end
                PH_MUL: begin
                    bit_q <= bit_q + BW'(1);
                    if (bit_q == BW'(SYM_W - 1)) phase_q <= PH_UPD;
                end
                PH_UPD: begin
                    wcnt_q  <= wrap ? '0 : wcnt_q + DW'(1);
                    phase_q <= PH_READY;
                end
                PH_PAR: begin
                    wcnt_q <= wrap ? '0 : wcnt_q + DW'(1);
                    par_q  <= par_q + PW'(1);
                    if (par_done) phase_q <= PH_IDLE;
                end
                default: ;
            endcase
        end
    end

    assign depth = depth_q;
    assign wcnt  = wcnt_q;

endmodule

// File: rtl/rs_ilv_encoder.sv
module rs_ilv_encoder
    import rs_ilv_pkg::*;
#(
    parameter int NPAR      = 32,
    parameter int MAX_DEPTH = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start,
    input  logic [MAX_DEPTH-1:0] depth_sel,
    input  logic                 load_mode,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic [SYM_W-1:0]     in_data,
    output logic                 out_valid,
    output logic [SYM_W-1:0]     out_data
);
    localparam int DW = $clog2(MAX_DEPTH + 1);

    ctrl_t                      ctrl;
    logic [DW-1:0]              depth_w;
    logic [DW-1:0]              wcnt_w;
    sym_t                       head;
    sym_t                       fb_in;
    logic [NPAR-1:0][SYM_W-1:0] prod;

    assign fb_in = in_data ^ head;

    rs_seq #(.NPAR(NPAR), .MAX_DEPTH(MAX_DEPTH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .depth_sel (depth_sel),
        .load_mode (load_mode),
        .in_valid  (in_valid),
        .in_ready  (in_ready),
        .ctrl      (ctrl),
        .depth     (depth_w),
        .wcnt      (wcnt_w)
    );

    rs_bitserial_bank #(.NPAR(NPAR)) u_bank (
        .clk    (clk),
        .rst    (rst),
        .load   (ctrl.accept),
        .step   (ctrl.mul_step),
        .fb_in  (fb_in),
        .prod_o (prod)
    );

    rs_rem_array #(.NPAR(NPAR), .MAX_DEPTH(MAX_DEPTH)) u_rem (
        .clk   (clk),
        .rst   (rst),
        .clr   (start),
        .shift (ctrl.shift),
        .feed  (ctrl.feed),
        .depth (depth_w),
        .prod  (prod),
        .head  (head)
    );

    always_ff @(posedge clk) begin
        if (rst || start) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else if (ctrl.accept) begin
            out_valid <= 1'b1;
            out_data  <= in_data;
        end else if (ctrl.emit_par) begin
            out_valid <= 1'b1;
            out_data  <= head;
        end else begin
            out_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/rs_ilv_encoder_chk.sv
module rs_ilv_encoder_chk #(
    parameter  int MAX_DEPTH = 5,
    localparam int DW        = $clog2(MAX_DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          load_mode,
    input logic          in_valid,
    input logic          in_ready,
    input logic [7:0]    in_data,
    input logic          out_valid,
    input logic [7:0]    out_data,
    input logic [DW-1:0] depth,
    input logic [DW-1:0] wcnt
);
    AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !start) |=> (out_valid && out_data == $past(in_data))); // R2

    AST_READY_DROPS: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready && !start) |=> !in_ready); // R7

    AST_NO_READY_IN_PARITY: assert property (@(posedge clk) disable iff (rst)
        !load_mode |-> !in_ready); // R7

    AST_DEPTH_LEGAL: assert property (@(posedge clk) disable iff (rst)
        (depth >= DW'(1)) && (depth <= DW'(MAX_DEPTH))); // R4

    AST_DEPTH_HOLD: assert property (@(posedge clk) disable iff (rst)
        !start |=> $stable(depth)); // R6

    AST_WORD_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        wcnt < depth); // R3

endmodule

bind rs_ilv_encoder rs_ilv_encoder_chk #(.MAX_DEPTH(MAX_DEPTH)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .start     (start),
    .load_mode (load_mode),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_data  (out_data),
    .depth     (depth_w),
    .wcnt      (wcnt_w)
);

// File: tb/rs_ilv_encoder_tb_top.sv
`timescale 1ns/1ps
module rs_ilv_encoder_tb_top;
    localparam int NPAR = 32;
    localparam int MAXD = 5;
    localparam int KINF = 223;

    logic       clk = 1'b0;
    logic       rst;
    logic       start;
    logic [4:0] depth_sel;
    logic       load_mode;
    logic       in_valid;
    logic       in_ready;
    logic [7:0] in_data;
    logic       out_valid;
    logic [7:0] out_data;

    always #4 clk = ~clk;

    rs_ilv_encoder dut_i (
        .clk(clk), .rst(rst), .start(start), .depth_sel(depth_sel),
        .load_mode(load_mode), .in_valid(in_valid), .in_ready(in_ready),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
    );

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [7:0] gpoly [0:NPAR];
    logic [7:0] info_m [MAXD][KINF];
    logic [7:0] par_m  [MAXD][NPAR];
    logic [7:0] exp_q [$];
    logic [7:0] got_q [$];

    always @(negedge clk) if (out_valid) got_q.push_back(out_data);

    function automatic logic [7:0] tb_mul(logic [7:0] a, logic [7:0] b);
        logic [7:0] p  = 8'h00;
        logic [7:0] aa = a;
        logic [7:0] bb = b;
        for (int i = 0; i < 8; i++) begin
            if (bb[0]) p = p ^ aa;
            aa = aa[7] ? ({aa[6:0], 1'b0} ^ 8'h87) : {aa[6:0], 1'b0};
            bb = bb >> 1;
        end
        return p;
    endfunction

    function automatic logic [7:0] tb_root(int e);
        logic [7:0] r = 8'h01;
        for (int i = 0; i < e; i++) r = tb_mul(r, 8'h02);
        return r;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic report();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    task automatic send(logic [7:0] s, bit measure);
        int n;
        @(negedge clk);
        while (!in_ready) @(negedge clk);
        in_valid = 1'b1;
        in_data  = s;
        @(negedge clk);
        in_valid = 1'b0;
        if (measure) begin
            chk(out_valid && out_data == s, "R2", "pass-through", int'(out_data), int'(s));
            n = 0;
            while (!in_ready && n < 50) begin
                n++;
                @(negedge clk);
            end
            chk(n == 9, "R7", "ready gap cycles", n, 9);
        end
    endtask

    task automatic pulse_start(logic [4:0] sel);
        @(negedge clk);
        depth_sel = sel;
        start     = 1'b1;
        @(negedge clk);
        start     = 1'b0;
        got_q.delete();
    endtask

    task automatic run_group(logic [4:0] sel, int dexp, int ninfo, int seed,
                             logic [4:0] sel_mid, bit measure);
        logic [7:0] bufm [0:KINF+NPAR-1];
        logic [7:0] c;
        logic [7:0] s;
        logic [7:0] rt;
        int         total;
        int         bad;
        for (int cw = 0; cw < dexp; cw++)
            for (int i = 0; i < ninfo; i++)
                info_m[cw][i] = 8'((seed * 7 + i * 29 + cw * 83 + i * i * 3) & 255);
        for (int cw = 0; cw < dexp; cw++) begin
            for (int j = 0; j < ninfo + NPAR; j++) bufm[j] = (j < ninfo) ? info_m[cw][j] : 8'h00;
            for (int i = 0; i < ninfo; i++) begin
                c = bufm[i];
                for (int j = 1; j <= NPAR; j++) bufm[i+j] = bufm[i+j] ^ tb_mul(c, gpoly[NPAR-j]);
            end
            for (int q = 0; q < NPAR; q++) par_m[cw][q] = bufm[ninfo+q];
        end
        exp_q.delete();
        for (int i = 0; i < ninfo; i++)
            for (int cw = 0; cw < dexp; cw++) exp_q.push_back(info_m[cw][i]);
        for (int q = 0; q < NPAR; q++)
            for (int cw = 0; cw < dexp; cw++) exp_q.push_back(par_m[cw][q]);

        pulse_start(sel);
        for (int i = 0; i < ninfo; i++)
            for (int cw = 0; cw < dexp; cw++) begin
                if (i == ninfo / 2 && cw == 0) depth_sel = sel_mid;
                send(info_m[cw][i], measure && i == 0 && cw == 0);
            end
        load_mode = 1'b0;
        repeat (NPAR * dexp + 30) @(negedge clk);

        total = (ninfo + NPAR) * dexp;
        chk(got_q.size() == total, "R3", "stream length", got_q.size(), total);
        if (got_q.size() == total) begin
            for (int k = 0; k < total; k++)
                chk(got_q[k] == exp_q[k], "R1", "symbol vs model", int'(got_q[k]), int'(exp_q[k]));
            for (int cw = 0; cw < dexp; cw++) begin
                rt  = tb_root(112);
                bad = 0;
                for (int r = 0; r < NPAR; r++) begin
                    s = 8'h00;
                    for (int col = 0; col < ninfo + NPAR; col++)
                        s = tb_mul(s, rt) ^ got_q[col * dexp + cw];
                    if (s != 8'h00) bad++;
                    rt = tb_mul(rt, 8'h02);
                end
                chk(bad == 0, "R1", "nonzero root evaluations", bad, 0);
            end
        end
        chk(!in_ready && !out_valid, "R8", "idle after parity", int'({in_ready, out_valid}), 0);
        load_mode = 1'b1;
    endtask

    initial begin
        logic [7:0] t [0:NPAR];
        logic [7:0] r;
        rst       = 1'b1;
        start     = 1'b0;
        load_mode = 1'b1;
        in_valid  = 1'b0;
        in_data   = 8'h00;
        depth_sel = 5'b00001;

        for (int j = 0; j <= NPAR; j++) gpoly[j] = 8'h00;
        gpoly[0] = 8'h01;
        r = tb_root(112);
        for (int i = 0; i < NPAR; i++) begin
            for (int j = 0; j <= NPAR; j++) t[j] = gpoly[j];
            for (int j = 0; j <= NPAR; j++)
                gpoly[j] = ((j > 0) ? t[j-1] : 8'h00) ^ tb_mul(t[j], r);
            r = tb_mul(r, 8'h02);
        end

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(!in_ready, "R8", "in_ready after reset", int'(in_ready), 0);
        chk(!out_valid, "R8", "out_valid after reset", int'(out_valid), 0);

        // R5: zero select keeps the reset depth of 1
        run_group(5'b00000, 1, 15, 3, 5'b00000, 1'b1);
        // R4: full-length sweep of every depth
        for (int d = 1; d <= MAXD; d++)
            run_group(5'(1 << (d - 1)), d, KINF, d * 11, 5'(1 << (d - 1)), 1'b0);
        // R5: two bits set keeps depth 5
        run_group(5'b00110, 5, 12, 21, 5'b00110, 1'b0);
        run_group(5'b00010, 2, 10, 22, 5'b00010, 1'b0);
        run_group(5'b00000, 2, 10, 23, 5'b00000, 1'b0);
        // R6: depth_sel moves to depth 5 in the middle of a depth-3 group
        run_group(5'b00100, 3, 40, 24, 5'b10000, 1'b0);
        // R9: abort a depth-4 group, then restart
        pulse_start(5'b01000);
        for (int k = 0; k < 30; k++) send(8'(k * 17 + 5), 1'b0);
        run_group(5'b01000, 4, 60, 25, 5'b01000, 1'b0);

        done = 1;
        report();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            report();
        end
    end

endmodule